// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a processor 24 general-purpose parallel lines through a small byte-wide register interface. The lines form three 8-bit ports: A, B and C. Port C is split into a lower and an upper 4-bit half, and each half has its own direction. A 2-bit address picks port A, port B, port C or the control word. Accesses are qualified by an active-low select together with active-low read and write strobes. Writes are taken on the rising clock edge. Read data is combinational and is zero whenever no read is in progress.

A control write has two meanings, chosen by bit 7 of the written byte. With bit 7 set, the byte is a configuration word that gives the four group directions. With bit 7 clear, the byte is a command that forces one port C bit to 0 or 1. Pads are not modelled: each port has an output-value bus and an output-enable bus, and the integration around the block drives the pads from these.

Top module: `pario_unit`

## Requirements
- R1: The bus has effect only when `sel_n` is 0. A write is taken on a rising edge where `sel_n`=0 and `wr_n`=0. `rdata` is 0 unless `sel_n`=0 and `rd_n`=0.
- R2: The configuration word sets the directions, with 1 meaning input. Bit 4 is port A, bit 1 is port B, bit 0 is port C bits 3:0, and bit 3 is port C bits 7:4. Every bit of an output group has its enable at 1, and every bit of an input group has it at 0.
- R3: A write to address 0, 1 or 2 loads the output latch of port A, B or C. `pa_out`, `pb_out` and `pc_out` always show their latches. The latches keep their value until the next write that changes them.
- R4: Reset sets the stored configuration word to 8'h9B (all groups input), forces all output enables to 0 and clears all latches to 0.
- R5: A read of an input group returns the current pin level. A read of an output group returns its latch. Port C is decided separately for each half.
- R6: A control write with bit 7 = 0 sets port C latch bit `wdata[3:1]` to `wdata[0]`. Bits 6:4 are ignored. No other latch bit changes, and no direction changes.
- R7: A read of address 3 returns the last configuration word. Single-bit commands do not alter it.
- R8: Writing a configuration word clears all three output latches to 0.
- R9: When a read and a write hit the same address in the same cycle, `rdata` shows the value from before the edge. The new value appears once the edge has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | 0 = A, 1 = B, 2 = C, 3 = control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
A read and a write can fall in the same cycle on the same port, because the read path is combinational and the latch updates on the edge. The bench provokes this by holding both strobes low on port C while port C is configured as output. It samples `rdata` before the edge and expects the old latch value. It samples again after the edge and expects the written byte. The bench also checks that the single-bit command and the directions stay independent: it applies every bit index and value, with junk in the ignored bits, and checks the directions and the other ports after each one.

// File: rtl/pario_pkg.sv
package pario_pkg;

  typedef enum logic [1:0] {
    PSEL_A   = 2'd0,
    PSEL_B   = 2'd1,
    PSEL_C   = 2'd2,
    PSEL_CTL = 2'd3
  } psel_e;

  // control word field positions (decoded by software, so fixed)
  localparam int unsigned CW_KIND   = 7;
  localparam int unsigned CW_DIR_A  = 4;
  localparam int unsigned CW_DIR_CH = 3;
  localparam int unsigned CW_DIR_B  = 1;
  localparam int unsigned CW_DIR_CL = 0;

  localparam logic [7:0] CW_RESET = 8'h9B;

  typedef struct packed {
    logic a_in;
    logic b_in;
    logic cl_in;
    logic ch_in;
  } dir_t;

  function automatic dir_t dir_of(input logic [7:0] cw);
    dir_t d;
    d.a_in  = cw[CW_DIR_A];
    d.b_in  = cw[CW_DIR_B];
    d.cl_in = cw[CW_DIR_CL];
    d.ch_in = cw[CW_DIR_CH];
    return d;
  endfunction

endpackage

// File: rtl/pario_cfg.sv
module pario_cfg
  import pario_pkg::*;
#(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_we,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] mode_q,
  output dir_t          dir
);

  logic [PW-1:0] mode_d;

  always_comb begin
    mode_d = mode_q;
    if (mode_we) mode_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= PW'(CW_RESET);
    else if (mode_we) mode_q <= mode_d;
  end

  assign dir = dir_of(mode_q[7:0]);

endmodule

// File: rtl/pario_latch.sv
module pario_latch #(
  parameter int unsigned PW = 8,
  localparam int unsigned IW = $clog2(PW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_a,
  input  logic          wr_b,
  input  logic          wr_c,
  input  logic          bsr_we,
  input  logic [IW-1:0] bsr_idx,
  input  logic          bsr_val,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] la_q,
  output logic [PW-1:0] lb_q,
  output logic [PW-1:0] lc_q
);

  logic [PW-1:0] la_d, lb_d, lc_d;
  logic          la_en, lb_en, lc_en;

  assign la_en = clr | wr_a;
  assign lb_en = clr | wr_b;
  assign lc_en = clr | wr_c | bsr_we;

  always_comb begin
    la_d = clr ? '0 : wdata;
    lb_d = clr ? '0 : wdata;
  end

  for (genvar g = 0; g < PW; g++) begin : g_cbit
    logic hit;
    assign hit     = bsr_we && (bsr_idx == IW'(g));
    assign lc_d[g] = clr  ? 1'b0 :
                     wr_c ? wdata[g] :
                     hit  ? bsr_val : lc_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     la_q <= '0;
    else if (la_en) la_q <= la_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lb_q <= '0;
    else if (lb_en) lb_q <= lb_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lc_q <= '0;
    else if (lc_en) lc_q <= lc_d;
  end

endmodule

// File: rtl/pario_rdmux.sv
module pario_rdmux
  import pario_pkg::*;
#(
  parameter int unsigned PW = 8,
  localparam int unsigned HW = PW / 2
) (
  input  logic          rd_en,
  input  psel_e         asel,
  input  dir_t          dir,
  input  logic [PW-1:0] mode_q,
  input  logic [PW-1:0] la_q,
  input  logic [PW-1:0] lb_q,
  input  logic [PW-1:0] lc_q,
  input  logic [PW-1:0] pa_in,
  input  logic [PW-1:0] pb_in,
  input  logic [PW-1:0] pc_in,
  output logic [PW-1:0] rdata
);

  logic [PW-1:0] pc_view;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic half_in;
    if (h == 0) begin : g_lo
      assign half_in = dir.cl_in;
    end else begin : g_hi
      assign half_in = dir.ch_in;
    end
    assign pc_view[h*HW +: HW] = half_in ? pc_in[h*HW +: HW] : lc_q[h*HW +: HW];
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (asel)
        PSEL_A:   rdata = dir.a_in ? pa_in : la_q;
        PSEL_B:   rdata = dir.b_in ? pb_in : lb_q;
        PSEL_C:   rdata = pc_view;
        default:  rdata = mode_q;
      endcase
    end
  end

endmodule

// File: rtl/pario_unit.sv
module pario_unit
  import pario_pkg::*;
#(
  parameter int unsigned PW = 8,
  localparam int unsigned HW = PW / 2,
  localparam int unsigned IW = $clog2(PW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [1:0]    addr,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] rdata,
  input  logic [PW-1:0] pa_in,
  output logic [PW-1:0] pa_out,
  output logic [PW-1:0] pa_oe,
  input  logic [PW-1:0] pb_in,
  output logic [PW-1:0] pb_out,
  output logic [PW-1:0] pb_oe,
  input  logic [PW-1:0] pc_in,
  output logic [PW-1:0] pc_out,
  output logic [PW-1:0] pc_oe
);

  // asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  logic  bus_wr, bus_rd, mode_we, bsr_we;
  psel_e asel;
  dir_t  dir;
  logic [PW-1:0] mode_q, la_q, lb_q, lc_q;

  assign bus_wr  = !sel_n && !wr_n;
  assign bus_rd  = !sel_n && !rd_n;
  assign asel    = psel_e'(addr);
  assign mode_we = bus_wr && (asel == PSEL_CTL) &&  wdata[CW_KIND];
  assign bsr_we  = bus_wr && (asel == PSEL_CTL) && !wdata[CW_KIND];

  pario_cfg #(.PW(PW)) i_cfg (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .mode_we (mode_we),
    .wdata   (wdata),
    .mode_q  (mode_q),
    .dir     (dir)
  );

  pario_latch #(.PW(PW)) i_latch (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .clr     (mode_we),
    .wr_a    (bus_wr && (asel == PSEL_A)),
    .wr_b    (bus_wr && (asel == PSEL_B)),
    .wr_c    (bus_wr && (asel == PSEL_C)),
    .bsr_we  (bsr_we),
    .bsr_idx (wdata[IW:1]),
    .bsr_val (wdata[0]),
    .wdata   (wdata),
    .la_q    (la_q),
    .lb_q    (lb_q),
    .lc_q    (lc_q)
  );

  pario_rdmux #(.PW(PW)) i_rdmux (
    .rd_en  (bus_rd),
    .asel   (asel),
    .dir    (dir),
    .mode_q (mode_q),
    .la_q   (la_q),
    .lb_q   (lb_q),
    .lc_q   (lc_q),
    .pa_in  (pa_in),
    .pb_in  (pb_in),
    .pc_in  (pc_in),
    .rdata  (rdata)
  );

  assign pa_out = la_q;
  assign pb_out = lb_q;
  assign pc_out = lc_q;
  assign pa_oe  = {PW{!dir.a_in}};
  assign pb_oe  = {PW{!dir.b_in}};
  assign pc_oe  = {{HW{!dir.ch_in}}, {HW{!dir.cl_in}}};

endmodule

// File: rtl/pario_chk.sv
module pario_chk #(
  parameter int unsigned PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic [1:0]    addr,
  input logic [PW-1:0] wdata,
  input logic [PW-1:0] rdata,
  input logic [PW-1:0] pa_out,
  input logic [PW-1:0] pa_oe,
  input logic [PW-1:0] pb_out,
  input logic [PW-1:0] pb_oe,
  input logic [PW-1:0] pc_out,
  input logic [PW-1:0] pc_oe
);

  logic bw, ctl_wr, ctl_rd;
  assign bw     = !sel_n && !wr_n;
  assign ctl_wr = bw && (addr == 2'd3);
  assign ctl_rd = !sel_n && !rd_n && (addr == 2'd3);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bw |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
             $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

  p_bsr_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !wdata[7]) |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) &&
                               $stable(pa_out) && $stable(pb_out)));

  p_bsr_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !wdata[7]) |=> ($countones(pc_out ^ $past(pc_out)) <= 1));

  p_mode_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wdata[7]) |=> (pa_out == '0 && pb_out == '0 && pc_out == '0));

  p_rd_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n || rd_n) |-> (rdata == '0));

  p_ctl_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd |-> rdata[7]);

endmodule

bind pario_unit pario_chk #(.PW(PW)) i_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .sel_n  (sel_n),
  .rd_n   (rd_n),
  .wr_n   (wr_n),
  .addr   (addr),
  .wdata  (wdata),
  .rdata  (rdata),
  .pa_out (pa_out),
  .pa_oe  (pa_oe),
  .pb_out (pb_out),
  .pb_oe  (pb_oe),
  .pc_out (pc_out),
  .pc_oe  (pc_oe)
);

// File: tb/test_pario_unit.sv
module test_pario_unit;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int  tests = 0;
  int  fails = 0;
  bit  done  = 1'b0;

  logic [7:0] mw, la, lb, lc;

  always #(CLK_P/2) clk = ~clk;

  pario_unit i_pario_unit (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    sel_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    sel_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    sel_n = 1'b0; rd_n = 1'b0; addr = a;
    #1 v = rdata;
    sel_n = 1'b1; rd_n = 1'b1;
  endtask

  function automatic logic [7:0] exp_oe_a(input logic [7:0] cw); return {8{~cw[4]}}; endfunction
  function automatic logic [7:0] exp_oe_b(input logic [7:0] cw); return {8{~cw[1]}}; endfunction
  function automatic logic [7:0] exp_oe_c(input logic [7:0] cw); return {{4{~cw[3]}}, {4{~cw[0]}}}; endfunction

  task automatic chk_outs(input string req);
    chk(req, pa_out, la); chk(req, pb_out, lb); chk(req, pc_out, lc);
    chk(req, pa_oe, exp_oe_a(mw)); chk(req, pb_oe, exp_oe_b(mw)); chk(req, pc_oe, exp_oe_c(mw));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mw = 8'h9B; la = 8'h00; lb = 8'h00; lc = 8'h00;
  endtask

  initial begin
    logic [7:0] v, ea, eb, ec;
    do_reset();
    // R4: reset state
    chk_outs("R4");
    bus_rd(2'd3, v); chk("R4 cfg", v, 8'h9B);

    // R2 R3 R5 R7 R8: all sixteen direction combinations
    for (int k = 0; k < 16; k++) begin
      logic [7:0] cw;
      // fill latches first so the clear on the next configuration is visible
      bus_wr(2'd3, 8'h80); mw = 8'h80;
      bus_wr(2'd0, 8'hFF); bus_wr(2'd1, 8'hFF); bus_wr(2'd2, 8'hFF);
      cw = 8'h80;
      cw[4] = k[0]; cw[3] = k[1]; cw[1] = k[2]; cw[0] = k[3];
      bus_wr(2'd3, cw);
      mw = cw; la = 8'h00; lb = 8'h00; lc = 8'h00;
      chk_outs("R8/R2");
      bus_rd(2'd3, v); chk("R7", v, cw);
      la = 8'(k * 37 + 5); lb = 8'(k * 53 + 11); lc = 8'(k * 29 + 7);
      bus_wr(2'd0, la); bus_wr(2'd1, lb); bus_wr(2'd2, lc);
      chk_outs("R3");
      pa_in = ~la ^ 8'(k); pb_in = 8'hA5 ^ 8'(k * 3); pc_in = 8'h3C ^ 8'(k * 9);
      ea = cw[4] ? pa_in : la;
      eb = cw[1] ? pb_in : lb;
      ec = {cw[3] ? pc_in[7:4] : lc[7:4], cw[0] ? pc_in[3:0] : lc[3:0]};
      bus_rd(2'd0, v); chk("R5 A", v, ea);
      bus_rd(2'd1, v); chk("R5 B", v, eb);
      bus_rd(2'd2, v); chk("R5 C", v, ec);
    end

    // R6: every bit index and value, junk in the ignored bits
    for (int m = 0; m < 2; m++) begin
      logic [7:0] cw;
      cw = (m == 0) ? 8'h80 : 8'h89;
      bus_wr(2'd3, cw); mw = cw; la = 8'h00; lb = 8'h00; lc = 8'h00;
      bus_wr(2'd0, 8'h5A); la = 8'h5A;
      bus_wr(2'd1, 8'hC3); lb = 8'hC3;
      for (int i = 0; i < 16; i++) begin
        logic [7:0] cmd;
        cmd = {1'b0, 3'(i * 5 + 3), 3'(i >> 1), 1'(i)};
        bus_wr(2'd3, cmd);
        lc[i >> 1] = 1'(i);
        chk_outs("R6");
        bus_rd(2'd3, v); chk("R7 after cmd", v, cw);
      end
    end

    // R1: accesses without select
    bus_wr(2'd3, 8'h80); mw = 8'h80; la = 8'h00; lb = 8'h00; lc = 8'h00;
    @(negedge clk); sel_n = 1'b1; wr_n = 1'b0; addr = 2'd0; wdata = 8'h77;
    @(negedge clk); wr_n = 1'b1;
    chk("R1 no write", pa_out, 8'h00);
    @(negedge clk); sel_n = 1'b1; wr_n = 1'b0; addr = 2'd3; wdata = 8'h9B;
    @(negedge clk); wr_n = 1'b1;
    chk("R1 no cfg", pa_oe, 8'hFF);
    @(negedge clk); sel_n = 1'b1; rd_n = 1'b0; addr = 2'd3;
    #1 chk("R1 rd idle", rdata, 8'h00);
    rd_n = 1'b1;
    @(negedge clk); sel_n = 1'b0; addr = 2'd3;
    #1 chk("R1 sel only", rdata, 8'h00);
    sel_n = 1'b1;

    // R9: read and write of port C in one cycle
    bus_wr(2'd2, 8'h0F);
    @(negedge clk);
    sel_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; addr = 2'd2; wdata = 8'hF0;
    #1 chk("R9 before edge", rdata, 8'h0F);
    @(posedge clk); #1;
    chk("R9 after edge", rdata, 8'hF0);
    chk("R9 latch", pc_out, 8'hF0);
    @(negedge clk); sel_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;

    // R4: reset in mid-run returns everything to input
    do_reset();
    chk_outs("R4 again");
    bus_rd(2'd3, v); chk("R4 cfg again", v, 8'h9B);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule